// File: doc/BRIEF.md
# Multilevel Feedback Task Dispatcher

This block decides which task runs next on a single execution resource. Task identifiers arrive on a small input port and are placed in the most urgent of several ready queues. The dispatcher always takes the oldest task from the most urgent queue that holds anything. It then counts down that queue's time allowance, one step per `tick` pulse. The allowance doubles from each level to the next lower one.

A task that uses up its whole allowance without finishing is moved to the tail of the next less urgent queue. A task that runs out of its allowance in the least urgent queue goes back to the tail of that same queue. A `done` pulse retires the running task. Level 0 is the most urgent. A running task is never displaced before its allowance runs out, even when a more urgent task arrives. The surrounding system supplies the time base through `tick` and reports completion through `done`. It reads back which task holds the resource, from which level it was taken, and how much of its allowance is left.

Top module: `mlfq_dispatch`

## Requirements
- R1: During reset and in the cycle after it, `run_valid` and `overflow` are 0, `quantum_left` is 0 and every queue is empty.
- R2: Each arrival is appended to the tail of level 0. When the resource is free at a clock edge, the head of the lowest-numbered non-empty queue becomes the running task, as that queue stood before the edge. From the next cycle `run_valid` is 1, `run_id` and `run_level` show the task and its level, and `quantum_left` equals 2 << level, which gives 2, 4 and 8.
- R3: An arrival that finds level 0 holding 8 entries before the edge is dropped. `overflow` is 1 in the following cycle only, and stays 1 only while such arrivals continue.
- R4: A `tick` while a task runs lowers `quantum_left` by 1 in the next cycle, as long as neither expiry nor `done` applies. A `tick` while idle has no effect, and `quantum_left` stays 0 whenever `run_valid` is 0.
- R5: A `tick` that arrives with `quantum_left` = 1 and no `done` expires the task. The task goes to the tail of level min(level+1, 2), and at the same edge another ready task is dispatched if any queue held one before that edge.
- R6: A task in level 1 or 2 is dispatched only when all lower-numbered levels are empty.
- R7: An arrival never displaces the running task. The running task continues until it expires or is retired.
- R8: `done` while a task runs retires that task and frees the resource at that edge, and `done` takes precedence over a coincident `tick`. `done` while idle is ignored.
- R9: If an expiring task's destination queue already holds 8 entries, the task keeps running at its own level and `quantum_left` is reloaded to that level's allowance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arrive_valid | input | 1 | A new task arrives this cycle |
| arrive_id | input | 4 | Identifier of the arriving task |
| tick | input | 1 | One time-slice step |
| done | input | 1 | The running task has finished |
| run_valid | output | 1 | A task holds the resource |
| run_id | output | 4 | Identifier of the running task |
| run_level | output | 2 | Queue level the running task was taken from (0 most urgent) |
| quantum_left | output | 4 | Ticks remaining in the current allowance |
| overflow | output | 1 | An arrival was dropped in the previous cycle |

## Verification
Every effect of an input pulse, whether dispatch, countdown, expiry, retirement or overflow, is visible in the cycle after the clock edge that samples it. No result arrives later than that. The bench drives its inputs on the falling edge and advances a behavioural model of queues and the running slot by one step for those inputs. On the next falling edge, after the rising edge has updated the design, it compares every output with the model. Both sides judge queue fullness and the choice of level on the contents before the edge, so a task demoted into empty queues shows as one idle cycle in both.

// File: rtl/mlfq_pkg.sv
// Package: shared constants and helpers for the multilevel dispatcher.
// Assumes level 0 is the most urgent and the allowance doubles per level.
package mlfq_pkg;

    localparam int DEF_LEVELS = 3;
    localparam int DEF_DEPTH  = 8;
    localparam int DEF_ID_W   = 4;
    localparam int DEF_BASE_Q = 2;

    // Allowance in ticks for a given level.
    function automatic int level_quantum(input int base, input int lvl);
        return base << lvl;
    endfunction

    // Width needed for a count from 0 to max_val.
    function automatic int count_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/mlfq_fifo.sv
// Module: one ready queue, a circular FIFO of task identifiers.
// Assumes a push when full and a pop when empty are ignored, judged on
// the occupancy before the edge. Push and pop may occur in one cycle.
module mlfq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam int CW = mlfq_pkg::count_width(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    // Qualify requests against the occupancy before the edge.
    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = store[rd_ptr];

    // Write storage; no reset needed for the data words.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mlfq_pick.sv
// Module: fixed-priority selector over queue emptiness flags.
// Assumes index 0 is the most urgent; purely combinational.
module mlfq_pick #(
    parameter int LEVELS = 3,
    parameter int LVL_W  = 2
) (
    input  logic [LEVELS-1:0] empty,
    output logic              any_ready,
    output logic [LVL_W-1:0]  pick
);
    // Scan from least to most urgent so the most urgent non-empty wins.
    always_comb begin
        any_ready = 1'b0;
        pick      = '0;
        for (int l = LEVELS - 1; l >= 0; l--) begin
            if (!empty[l]) begin
                any_ready = 1'b1;
                pick      = LVL_W'(l);
            end
        end
    end
endmodule

// File: rtl/mlfq_dispatch.sv
// Module: multilevel feedback task dispatcher (top).
// Holds one queue per level, runs one task at a time, counts its allowance
// on tick, demotes on expiry and retires on done. Assumes tick and done
// are single-cycle pulses and that LEVELS is at least 2.
module mlfq_dispatch #(
    parameter int LEVELS = mlfq_pkg::DEF_LEVELS,
    parameter int DEPTH  = mlfq_pkg::DEF_DEPTH,
    parameter int ID_W   = mlfq_pkg::DEF_ID_W,
    parameter int BASE_Q = mlfq_pkg::DEF_BASE_Q,
    localparam int LVL_W = (LEVELS < 2) ? 1 : $clog2(LEVELS),
    localparam int QW    = mlfq_pkg::count_width(BASE_Q << (LEVELS - 1))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arrive_valid,
    input  logic [ID_W-1:0]  arrive_id,
    input  logic             tick,
    input  logic             done,
    output logic             run_valid,
    output logic [ID_W-1:0]  run_id,
    output logic [LVL_W-1:0] run_level,
    output logic [QW-1:0]    quantum_left,
    output logic             overflow
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    logic [LEVELS-1:0] q_push, q_pop, q_empty, q_full;
    logic [ID_W-1:0]   q_push_data [LEVELS];
    logic [ID_W-1:0]   q_head      [LEVELS];

    logic             any_ready;
    logic [LVL_W-1:0] pick_lvl;
    logic             expire, retire, demote_blocked, slot_free, dispatch;
    logic [LVL_W-1:0] dest_lvl;

    // Allowance for a level, narrowed to the counter width.
    function automatic logic [QW-1:0] quantum_of(input logic [LVL_W-1:0] lvl);
        return QW'(mlfq_pkg::level_quantum(BASE_Q, int'(lvl)));
    endfunction

    // One queue per level.
    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_level
            mlfq_fifo #(.DEPTH(DEPTH), .W(ID_W)) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (q_push[g]),
                .push_data (q_push_data[g]),
                .pop       (q_pop[g]),
                .head      (q_head[g]),
                .empty     (q_empty[g]),
                .full      (q_full[g])
            );
        end
    endgenerate

    mlfq_pick #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_pick (
        .empty     (q_empty),
        .any_ready (any_ready),
        .pick      (pick_lvl)
    );

    // Classify what happens to the running slot at this edge.
    always_comb begin
        retire         = run_valid && done;
        expire         = run_valid && tick && !done && (quantum_left == QW'(1));
        dest_lvl       = (run_level == LAST_LVL) ? run_level : run_level + 1'b1;
        demote_blocked = expire && q_full[dest_lvl];
        slot_free      = (!run_valid || retire || expire) && !demote_blocked;
        dispatch       = slot_free && any_ready;
    end

    // Route arrivals, demotions and the dispatch pop to the queues.
    always_comb begin
        for (int l = 0; l < LEVELS; l++) begin
            q_pop[l]       = dispatch && (pick_lvl == LVL_W'(l));
            q_push[l]      = 1'b0;
            q_push_data[l] = arrive_id;
            if (l == 0) begin
                q_push[l] = arrive_valid;
            end else if (expire && !demote_blocked && dest_lvl == LVL_W'(l)) begin
                q_push[l]      = 1'b1;
                q_push_data[l] = run_id;
            end
        end
    end

    // Running slot: dispatch, reload, release or countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_valid    <= 1'b0;
            run_id       <= '0;
            run_level    <= '0;
            quantum_left <= '0;
        end else if (dispatch) begin
            run_valid    <= 1'b1;
            run_id       <= q_head[pick_lvl];
            run_level    <= pick_lvl;
            quantum_left <= quantum_of(pick_lvl);
        end else if (demote_blocked) begin
            quantum_left <= quantum_of(run_level);
        end else if (slot_free) begin
            run_valid    <= 1'b0;
            run_id       <= '0;
            run_level    <= '0;
            quantum_left <= '0;
        end else if (run_valid && tick && !done) begin
            quantum_left <= quantum_left - 1'b1;
        end
    end

    // Dropped-arrival flag, one cycle per dropped arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) overflow <= 1'b0;
        else        overflow <= arrive_valid && q_full[0];
    end
endmodule

// File: rtl/mlfq_dispatch_checker.sv
// Module: temporal checks on the dispatcher ports, bound to the top.
// Assumes the same parameters as the instance it is bound to.
module mlfq_dispatch_checker #(
    parameter int LEVELS = 3,
    parameter int ID_W   = 4,
    parameter int BASE_Q = 2,
    parameter int LVL_W  = 2,
    parameter int QW     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arrive_valid,
    input logic             tick,
    input logic             done,
    input logic             run_valid,
    input logic [ID_W-1:0]  run_id,
    input logic [LVL_W-1:0] run_level,
    input logic [QW-1:0]    quantum_left,
    input logic             overflow
);
    // R4: idle implies a zero counter.
    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_valid |-> quantum_left == '0);

    // R2: a running task has a non-zero count within its level's allowance.
    assert_quantum_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_valid |-> (quantum_left != '0) &&
                      (int'(quantum_left) <= (BASE_Q << int'(run_level))));

    // R3: the drop flag only follows an arrival.
    assert_overflow_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(arrive_valid));

    // R7: without tick or done the running task is left untouched.
    assert_no_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && !tick && !done) |=>
            (run_valid && $stable(run_id) && $stable(run_level) && $stable(quantum_left)));

    // R4: a non-final tick counts down by one on the same task.
    assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && tick && !done && quantum_left > QW'(1)) |=>
            (run_valid && $stable(run_id) && quantum_left == $past(quantum_left) - 1'b1));
endmodule

bind mlfq_dispatch mlfq_dispatch_checker #(
    .LEVELS (LEVELS),
    .ID_W   (ID_W),
    .BASE_Q (BASE_Q),
    .LVL_W  (LVL_W),
    .QW     (QW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arrive_valid (arrive_valid),
    .tick         (tick),
    .done         (done),
    .run_valid    (run_valid),
    .run_id       (run_id),
    .run_level    (run_level),
    .quantum_left (quantum_left),
    .overflow     (overflow)
);

// File: tb/mlfq_dispatch_bench.sv
// Bench: drives directed and random phases and compares every output
// against a behavioural queue model on every cycle.
module mlfq_dispatch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arrive_valid = 1'b0;
    logic [3:0] arrive_id = '0;
    logic       tick = 1'b0;
    logic       done = 1'b0;
    logic       run_valid;
    logic [3:0] run_id;
    logic [1:0] run_level;
    logic [3:0] quantum_left;
    logic       overflow;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // Model state.
    int q0[$];
    int q1[$];
    int q2[$];
    bit m_rv = 0;
    int m_id = 0;
    int m_lvl = 0;
    int m_ql = 0;
    bit m_ovf = 0;
    int next_id = 1;

    always #5 clk = ~clk;

    mlfq_dispatch u_mlfq_dispatch (
        .clk(clk), .rst_n(rst_n), .arrive_valid(arrive_valid), .arrive_id(arrive_id),
        .tick(tick), .done(done), .run_valid(run_valid), .run_id(run_id),
        .run_level(run_level), .quantum_left(quantum_left), .overflow(overflow)
    );

    function automatic int qsize(int l);
        return (l == 0) ? q0.size() : (l == 1) ? q1.size() : q2.size();
    endfunction

    function automatic void qpush(int l, int v);
        if (l == 0) q0.push_back(v);
        else if (l == 1) q1.push_back(v);
        else q2.push_back(v);
    endfunction

    function automatic int qpop(int l);
        if (l == 0) return q0.pop_front();
        if (l == 1) return q1.pop_front();
        return q2.pop_front();
    endfunction

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("run_valid", int'(run_valid), int'(m_rv));
        check("quantum_left", int'(quantum_left), m_ql);
        check("overflow", int'(overflow), int'(m_ovf));
        if (m_rv) begin
            check("run_id", int'(run_id), m_id);
            check("run_level", int'(run_level), m_lvl);
        end
    endtask

    // One model step for the inputs about to be sampled.
    task automatic model_next(input bit av, input int aid, input bit tk, input bit dn);
        bit expire, retire, blocked, free, arr_ok;
        int tgt, pick, popped, old_id;
        retire  = m_rv && dn;
        expire  = m_rv && tk && !dn && (m_ql == 1);
        tgt     = (m_lvl == 2) ? 2 : m_lvl + 1;
        blocked = expire && (qsize(tgt) == 8);
        free    = (!m_rv || retire || expire) && !blocked;
        pick = -1;
        for (int l = 0; l < 3; l++) if (pick < 0 && qsize(l) > 0) pick = l;
        m_ovf  = av && (qsize(0) == 8);
        arr_ok = av && (qsize(0) < 8);
        old_id = m_id;
        popped = 0;
        if (free && pick >= 0) popped = qpop(pick);
        if (expire && !blocked) qpush(tgt, old_id);
        if (arr_ok) qpush(0, aid);
        if (free && pick >= 0) begin
            m_rv = 1; m_id = popped; m_lvl = pick; m_ql = 2 << pick;
        end else if (blocked) begin
            m_ql = 2 << m_lvl;
        end else if (free) begin
            m_rv = 0; m_id = 0; m_lvl = 0; m_ql = 0;
        end else if (m_rv && tk && !dn) begin
            m_ql = m_ql - 1;
        end
    endtask

    task automatic step(input bit av, input bit tk, input bit dn);
        int aid;
        @(negedge clk);
        compare_all();
        aid = next_id % 16;
        if (av) next_id++;
        arrive_valid = av;
        arrive_id    = 4'(aid);
        tick         = tk;
        done         = dn;
        model_next(av, aid, tk, dn);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("run_valid in reset", int'(run_valid), 0);
        check("quantum_left in reset", int'(quantum_left), 0);
        check("overflow in reset", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // R2: FIFO order and dispatch with no ticks, then retire.
        tag = "R2";
        step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
        repeat (2) step(0, 0, 0);
        repeat (3) begin step(0, 0, 1); step(0, 0, 0); end

        // R4: ticks and done while idle are ignored.
        tag = "R4";
        repeat (4) step(0, 1, 1);
        step(1, 0, 0); step(0, 0, 0);
        step(0, 1, 0); step(0, 0, 0);

        // R5: one task ticked through every level and back into the last.
        tag = "R5";
        repeat (30) step(0, 1, 0);

        // R7: arrival while a lower level task runs.
        tag = "R7";
        step(1, 0, 0);
        repeat (3) step(0, 0, 0);
        repeat (10) step(0, 1, 0);

        // R8: done coincident with tick, then drain.
        tag = "R8";
        repeat (6) begin step(0, 1, 1); step(0, 0, 0); end

        // R3: burst of arrivals overfills the top queue.
        tag = "R3";
        repeat (12) step(1, 0, 0);
        step(0, 0, 0);

        // R9: continuous ticks push all of them into level 1 until full.
        tag = "R9";
        repeat (60) step(0, 1, 0);

        // R6: random mix of arrivals, ticks and completions.
        tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 9) == 0);
        end
        repeat (40) step(0, 0, 1);
        @(negedge clk);
        compare_all();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule